// File: doc/BRIEF.md
# Supply Undervoltage Flag Controller

This block keeps three flags that describe the health of a node's supplies and uses them to override the operating mode that the standby and enable pins ask for. Qualified comparator outputs arrive as single-bit inputs. Two of them report that a logic supply is below its sleep threshold. Two more report that the battery is below its standby level and below its power-on level. A fifth input carries wake-up events. The outputs are the three flags, the resulting operating mode and the regulator inhibit (enable) signal.

Each logic supply has a low-time filter whose timeout is counted in clock cycles. When either filter expires, the combined supply flag is raised and the node is put to sleep. The same timers are then restarted as a waiting period. During that period nothing except a battery power-on event can clear the flag. After the period ends, a wake-up event or a power-on event clears it.

The supply flag machine has three states. UV_MONITOR means the flag is clear and the filters are watching. UV_WAIT means the flag is set and the waiting period is running. UV_ARMED means the flag is set and can be cleared. Its transitions are: trip (MONITOR to WAIT), wait_done (WAIT to ARMED), wake_release (ARMED to MONITOR) and pwon_release (WAIT or ARMED to MONITOR). The mode machine has four states: MD_NORMAL, MD_LISTEN, MD_STANDBY and MD_SLEEP. On each clock it moves to the state chosen by three inputs: forced sleep, forced standby, or the pin decode with the power-on sleep veto applied.

Top module: `supflag_ctrl`

## Requirements
- R1: The supply flag rises after the clock edge on which either logic-supply low input has been sampled high on TIMEOUT+1 consecutive edges. Default timeouts are 20 cycles for the first supply and 12 cycles for the second. A single low-to-high gap restarts the count.
- R2: While the supply flag is set, the mode output becomes Sleep (code 3) one cycle later and the inhibit output is low. The inhibit output is high in every other mode.
- R3: After the supply flag is set, both timers run again for the longer timeout. Wake-up events in that window are ignored. After the window, the flag stays set until a wake-up event clears it.
- R4: A power-on flag setting event clears the supply flag in any of its states.
- R5: The battery flag equals the battery-standby low input delayed by one cycle. While it is set and the supply flag is clear, the mode becomes Standby (code 2) one cycle later.
- R6: Without forcing, the mode follows the pins one cycle later. Standby pin 1 with enable 1 gives Normal (code 0). Standby pin 1 with enable 0 gives Listen (code 1). Standby pin 0 with enable 0 gives Standby (code 2). Standby pin 0 with enable 1 gives Sleep (code 3). When the battery flag clears, the mode returns to the pin mode.
- R7: The power-on flag is set on the edge after the power-on low input falls from high to low. While the flag is set, a pin request for Sleep yields Standby.
- R8: The power-on flag clears on the edge after the mode output shows Normal, unless a setting event occurs on that same edge.
- R9: When both flags are set, the mode is Sleep.
- R10: During reset the power-on flag is 1, the other flags are 0, the mode is Standby and the inhibit output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_low_i | input | 1 | First logic supply below sleep threshold |
| vio_low_i | input | 1 | Second logic supply below sleep threshold |
| bat_stb_low_i | input | 1 | Battery below standby threshold |
| bat_pwon_low_i | input | 1 | Battery below power-on threshold |
| wake_i | input | 1 | Wake-up event |
| stb_pin_i | input | 1 | Standby pin level |
| en_pin_i | input | 1 | Enable pin level |
| uv_sup_o | output | 1 | Combined logic-supply undervoltage flag |
| uv_bat_o | output | 1 | Battery undervoltage flag |
| pwon_o | output | 1 | Battery power-on flag |
| mode_o | output | 2 | Forced operating mode (0 Normal, 1 Listen, 2 Standby, 3 Sleep) |
| inh_o | output | 1 | Regulator inhibit, high enables the regulator |

## Verification
The hardest situation to reach is the waiting window, where the supply flag is set but cannot yet be released. From the ports it can only be seen by its absence of effect. The stimulus first trips the second supply at the exact filter boundary. It then sends a wake-up inside the window and raises the battery flag at the same time, to show the Sleep priority. After waiting well past the longer timeout, it shows that the flag does not clear by itself and that one wake-up pulse then releases it. A second trip is released during the window by a power-on event, which shows that this path ignores the window.

// File: rtl/supflag_pkg.sv
package supflag_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL  = 2'd0,
        MD_LISTEN  = 2'd1,
        MD_STANDBY = 2'd2,
        MD_SLEEP   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        UV_MONITOR = 2'd0,
        UV_WAIT    = 2'd1,
        UV_ARMED   = 2'd2
    } uv_state_e;

    function automatic mode_e decode_pins(input logic stb, input logic en);
        mode_e m;
        unique case ({stb, en})
            2'b11:   m = MD_NORMAL;
            2'b10:   m = MD_LISTEN;
            2'b00:   m = MD_STANDBY;
            default: m = MD_SLEEP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/supflag_lowcnt.sv
module supflag_lowcnt #(
    parameter int unsigned LIMIT = 20,
    parameter int unsigned CW    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic low,
    output logic at_limit
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run || low) begin
            if (!at_limit) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        at_limit = (cnt_q == CW'(LIMIT));
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/supflag_uvfsm.sv
module supflag_uvfsm
    import supflag_pkg::*;
#(
    parameter int unsigned VCC_LIMIT = 20,
    parameter int unsigned VIO_LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_low,
    input  logic vio_low,
    input  logic wake,
    input  logic pwon_set,
    output logic uv_flag
);
    localparam int unsigned NSUP = 2;
    localparam int unsigned MAXL = (VCC_LIMIT > VIO_LIMIT) ? VCC_LIMIT : VIO_LIMIT;
    localparam int unsigned CW   = $clog2(MAXL + 1);

    uv_state_e state_q, state_d;
    logic [NSUP-1:0] low_vec;
    logic [NSUP-1:0] at_lim;
    logic trip, wait_done, clear_cnt, run_cnt;

    always_comb begin
        low_vec = {vio_low, vcc_low};
    end

    for (genvar g = 0; g < NSUP; g++) begin : g_timer
        localparam int unsigned LIM = (g == 0) ? VCC_LIMIT : VIO_LIMIT;
        supflag_lowcnt #(.LIMIT(LIM), .CW(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear_cnt),
            .run      (run_cnt),
            .low      (low_vec[g]),
            .at_limit (at_lim[g])
        );
    end

    always_comb begin
        trip      = |(low_vec & at_lim);
        wait_done = &at_lim;
        run_cnt   = (state_q != UV_MONITOR);
        clear_cnt = pwon_set
                  || (state_q == UV_MONITOR && trip)
                  || (state_q == UV_ARMED && wake);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UV_MONITOR: if (!pwon_set && trip) state_d = UV_WAIT;
            UV_WAIT: begin
                if (pwon_set)       state_d = UV_MONITOR;
                else if (wait_done) state_d = UV_ARMED;
            end
            UV_ARMED:   if (pwon_set || wake) state_d = UV_MONITOR;
            default:    state_d = UV_MONITOR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UV_MONITOR;
        else        state_q <= state_d;
    end

    always_comb begin
        uv_flag = (state_q != UV_MONITOR);
    end

    assert_quiet_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UV_MONITOR && !vcc_low && !vio_low) |=> state_q == UV_MONITOR);
    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UV_WAIT && !pwon_set) |=> state_q != UV_MONITOR);
    assert_pwon_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwon_set |=> state_q == UV_MONITOR);

endmodule

// File: rtl/supflag_batt.sv
module supflag_batt (
    input  logic clk,
    input  logic rst_n,
    input  logic bat_stb_low,
    input  logic bat_pwon_low,
    input  logic mode_is_normal,
    output logic uv_bat,
    output logic pwon,
    output logic pwon_set
);
    logic dropped_q;

    always_comb begin
        pwon_set = dropped_q && !bat_pwon_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dropped_q <= 1'b0;
            uv_bat    <= 1'b0;
            pwon      <= 1'b1;
        end else begin
            dropped_q <= bat_pwon_low;
            uv_bat    <= bat_stb_low;
            if (pwon_set)            pwon <= 1'b1;
            else if (mode_is_normal) pwon <= 1'b0;
        end
    end

    assert_pwon_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_is_normal && !pwon_set) |=> !pwon);
    assert_pwon_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwon) |-> $past(dropped_q));

endmodule

// File: rtl/supflag_mode.sv
module supflag_mode
    import supflag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  uv_sup,
    input  logic  uv_bat,
    input  logic  pwon,
    input  logic  stb_pin,
    input  logic  en_pin,
    output mode_e mode,
    output logic  inh
);
    mode_e mode_q, mode_d, pin_mode;

    always_comb begin
        pin_mode = decode_pins(stb_pin, en_pin);
        mode_d   = mode_q;
        if (uv_sup) begin
            mode_d = MD_SLEEP;
        end else if (uv_bat) begin
            mode_d = MD_STANDBY;
        end else begin
            unique case (pin_mode)
                MD_NORMAL:  mode_d = MD_NORMAL;
                MD_LISTEN:  mode_d = MD_LISTEN;
                MD_STANDBY: mode_d = MD_STANDBY;
                MD_SLEEP:   mode_d = pwon ? MD_STANDBY : MD_SLEEP;
                default:    mode_d = MD_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MD_STANDBY;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode = mode_q;
        inh  = (mode_q != MD_SLEEP);
    end

    assert_sleep_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uv_sup |=> mode_q == MD_SLEEP);
    assert_bat_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_bat && !uv_sup) |=> mode_q == MD_STANDBY);
    assert_pwon_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwon && !uv_sup) |=> mode_q != MD_SLEEP);

endmodule

// File: rtl/supflag_ctrl.sv
module supflag_ctrl
    import supflag_pkg::*;
#(
    parameter int unsigned VCC_LIMIT = 20,
    parameter int unsigned VIO_LIMIT = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_low_i,
    input  logic       vio_low_i,
    input  logic       bat_stb_low_i,
    input  logic       bat_pwon_low_i,
    input  logic       wake_i,
    input  logic       stb_pin_i,
    input  logic       en_pin_i,
    output logic       uv_sup_o,
    output logic       uv_bat_o,
    output logic       pwon_o,
    output logic [1:0] mode_o,
    output logic       inh_o
);
    logic  uv_sup, uv_bat, pwon, pwon_set, inh;
    mode_e mode;

    supflag_uvfsm #(.VCC_LIMIT(VCC_LIMIT), .VIO_LIMIT(VIO_LIMIT)) u_uv (
        .clk      (clk),
        .rst_n    (rst_n),
        .vcc_low  (vcc_low_i),
        .vio_low  (vio_low_i),
        .wake     (wake_i),
        .pwon_set (pwon_set),
        .uv_flag  (uv_sup)
    );

    supflag_batt u_batt (
        .clk            (clk),
        .rst_n          (rst_n),
        .bat_stb_low    (bat_stb_low_i),
        .bat_pwon_low   (bat_pwon_low_i),
        .mode_is_normal (mode == MD_NORMAL),
        .uv_bat         (uv_bat),
        .pwon           (pwon),
        .pwon_set       (pwon_set)
    );

    supflag_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_sup  (uv_sup),
        .uv_bat  (uv_bat),
        .pwon    (pwon),
        .stb_pin (stb_pin_i),
        .en_pin  (en_pin_i),
        .mode    (mode),
        .inh     (inh)
    );

    always_comb begin
        uv_sup_o = uv_sup;
        uv_bat_o = uv_bat;
        pwon_o   = pwon;
        mode_o   = mode;
        inh_o    = inh;
    end

    assert_sleep_no_inh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_sup_o && $past(uv_sup_o)) |-> !inh_o);
    assert_sleep_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_sup_o && uv_bat_o) |=> mode_o == 2'd3);

endmodule

// File: tb/supflag_ctrl_bench.sv
module supflag_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_low = 0, vio_low = 0, bat_stb = 0, bat_pwon = 0, wake = 0;
    logic stb_pin = 1, en_pin = 1;
    logic uv_sup, uv_bat, pwon, inh;
    logic [1:0] mode;
    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic       uv;
        logic       bat;
        logic       pw;
        logic [1:0] md;
        logic       ih;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    supflag_ctrl u_supflag_ctrl (
        .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .vio_low_i(vio_low),
        .bat_stb_low_i(bat_stb), .bat_pwon_low_i(bat_pwon), .wake_i(wake),
        .stb_pin_i(stb_pin), .en_pin_i(en_pin), .uv_sup_o(uv_sup),
        .uv_bat_o(uv_bat), .pwon_o(pwon), .mode_o(mode), .inh_o(inh)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag, input logic u, input logic b,
                              input logic p, input logic [1:0] m, input logic i);
        exp_t e;
        e.tag = tag; e.uv = u; e.bat = b; e.pw = p; e.md = m; e.ih = i;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (uv_sup !== e.uv || uv_bat !== e.bat || pwon !== e.pw ||
                    mode !== e.md || inh !== e.ih) begin
                    fails++;
                    $display("FAIL %s: got uv=%0d bat=%0d pwon=%0d mode=%0d inh=%0d exp uv=%0d bat=%0d pwon=%0d mode=%0d inh=%0d",
                             e.tag, uv_sup, uv_bat, pwon, mode, inh, e.uv, e.bat, e.pw, e.md, e.ih);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        step(3);
        expect_now("R10 reset", 0, 0, 1, 2, 1);
        rst_n = 1'b1;
        step(1); expect_now("R6 normal pins", 0, 0, 1, 0, 1);
        step(1); expect_now("R8 pwon cleared", 0, 0, 0, 0, 1);
        en_pin = 0;
        step(1); expect_now("R6 listen", 0, 0, 0, 1, 1);
        stb_pin = 0;
        step(1); expect_now("R6 standby", 0, 0, 0, 2, 1);
        en_pin = 1;
        step(1); expect_now("R6 sleep inh low R2", 0, 0, 0, 3, 0);
        bat_pwon = 1;
        step(1); expect_now("R7 drop only", 0, 0, 0, 3, 0);
        bat_pwon = 0;
        step(1); expect_now("R7 pwon set", 0, 0, 1, 3, 0);
        step(1); expect_now("R7 sleep vetoed", 0, 0, 1, 2, 1);
        stb_pin = 1;
        step(1); expect_now("R8 normal pwon still", 0, 0, 1, 0, 1);
        step(1); expect_now("R8 pwon clears", 0, 0, 0, 0, 1);
        bat_stb = 1;
        step(1); expect_now("R5 bat flag", 0, 1, 0, 0, 1);
        step(1); expect_now("R5 forced standby", 0, 1, 0, 2, 1);
        bat_stb = 0;
        step(1); expect_now("R5 bat flag clear", 0, 0, 0, 2, 1);
        step(1); expect_now("R6 return to pins", 0, 0, 0, 0, 1);
        vcc_low = 1; step(20); vcc_low = 0; step(2);
        expect_now("R1 short vcc dip", 0, 0, 0, 0, 1);
        vio_low = 1; step(12); vio_low = 0; step(1); vio_low = 1; step(12); vio_low = 0; step(1);
        expect_now("R1 gap restarts", 0, 0, 0, 0, 1);
        vio_low = 1; step(12);
        expect_now("R1 vio boundary", 0, 0, 0, 0, 1);
        step(1); expect_now("R1 vio trip", 1, 0, 0, 0, 1);
        vio_low = 0;
        step(1); expect_now("R2 forced sleep", 1, 0, 0, 3, 0);
        wake = 1; step(1); wake = 0;
        expect_now("R3 wake ignored in wait", 1, 0, 0, 3, 0);
        bat_stb = 1;
        step(1); expect_now("R9 both flags", 1, 1, 0, 3, 0);
        step(1); expect_now("R9 sleep wins", 1, 1, 0, 3, 0);
        bat_stb = 0;
        step(25); expect_now("R3 flag persists", 1, 0, 0, 3, 0);
        wake = 1; step(1); wake = 0;
        expect_now("R3 wake clears", 0, 0, 0, 3, 0);
        step(1); expect_now("R2 inh restored", 0, 0, 0, 0, 1);
        vcc_low = 1; step(20);
        expect_now("R1 vcc boundary", 0, 0, 0, 0, 1);
        step(1); expect_now("R1 vcc trip", 1, 0, 0, 0, 1);
        vcc_low = 0;
        step(1); expect_now("R2 sleep again", 1, 0, 0, 3, 0);
        bat_pwon = 1; step(1); bat_pwon = 0;
        step(1); expect_now("R4 pwon clears in wait", 0, 0, 1, 3, 0);
        step(1); expect_now("R4 normal resumes", 0, 0, 1, 0, 1);
        step(1); expect_now("R8 pwon clears again", 0, 0, 0, 0, 1);
        step(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule